// File: doc/BRIEF.md
# Operand Specifier Parser

This block takes an instruction byte stream, one byte per cycle over a valid/ready handshake, and decodes a single operand specifier from it. The first byte sets the addressing mode and the register number. The parser then collects any displacement or immediate bytes that the mode calls for, least-significant byte first, and reports the mode, the register, a sign-extended 32-bit value and the total number of bytes the specifier used. An index prefix byte records an index register. The parser then reads a second, base specifier, and the prefix byte counts toward the total length.

The opcode decoder supplies the operand data size on `dsize`. The parser samples it when it accepts a lead byte, and it uses the size only to set the length of an immediate. When a specifier is complete, a one-cycle `done` pulse presents every field together. During that cycle the parser takes no byte, and after it the parser is ready for the next specifier.

Top module: `opspec_parser`

## Requirements
- R1: The lead byte is decoded as follows. If bits [7:6] are 00, the byte is a short literal. Otherwise bits [7:4] select the mode and bits [3:0] select the register: 4 is the index prefix, 5 register, 6 register deferred, 7 autodecrement, 8 autoincrement, 9 autoincrement deferred, A/C/E byte/word/long displacement and B/D/F the deferred forms of those. Autoincrement with register 15 is immediate. The `mode` output is 0 for a literal, 1 for an immediate, and the lead byte's bits [7:4] for every other mode.
- R2: A short literal is one byte long. Its 6-bit constant in bits [5:0] appears on `value` sign-extended from bit 5, `reg_num` reads 0, and `dsize` has no effect on it.
- R3: The register, register deferred, autodecrement, autoincrement and autoincrement deferred modes (register other than 15 for autoincrement) are one byte long and give `value` 0.
- R4: The byte, word and long displacement modes add 1, 2 and 4 bytes. The displacement is sign-extended from its own width to 32 bits.
- R5: Each deferred displacement form has the same length and value handling as its plain form.
- R6: An immediate adds 1, 2, 4 or 8 bytes for `dsize` 0, 1, 2 or 3, whatever its value. The value is sign-extended from the data size, and a quad immediate reports its low 32 bits. `dsize` is sampled only when the lead byte is accepted.
- R7: Multi-byte fields are assembled least-significant byte first.
- R8: An index prefix sets `idx_valid` and `idx_reg` to its register. A base specifier follows it, and the reported length is one plus the length of the base.
- R9: If the byte after an index prefix is another index prefix, a short literal or a register-mode byte, `illegal` is raised when `done` pulses, with length 2.
- R10: `done` is high for exactly one cycle, in the cycle after the final byte is accepted, and `in_ready` is low in that cycle. The fields hold until the next specifier's lead byte is accepted, and that byte clears `idx_valid` and `illegal` left from earlier specifiers.
- R11: Cycles with `in_valid` low are ignored and change neither the length nor the value.
- R12: After reset, `done`, `idx_valid` and `illegal` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte present |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| dsize | input | 2 | Operand data size: 0=1, 1=2, 2=4, 3=8 bytes |
| done | output | 1 | One-cycle pulse: specifier complete, fields valid |
| mode | output | 4 | Decoded mode code |
| reg_num | output | 4 | Base register number |
| value | output | 32 | Sign-extended literal, displacement or immediate |
| length | output | 4 | Total specifier length in bytes |
| idx_valid | output | 1 | An index prefix was present |
| idx_reg | output | 4 | Index register number |
| illegal | output | 1 | Illegal base after an index prefix |

## Verification
The bench targets several corner cases, each with the fault it would expose:
- Register 15 under autoincrement must become an immediate. A design that missed this would report a one-byte specifier and leave the following bytes unconsumed.
- Quad immediates, and a size change in the middle of an immediate, must both work. A design that resampled `dsize` for each byte would end the field early or late.
- Negative displacements and literals must be sign-extended from their own width. A design that extended from the wrong bit would return a positive value.
- Chains of index prefixes, and a register base after a prefix, must raise `illegal`. A specifier that follows an illegal one must show the flags cleared. A design that never cleared them would carry a stale `illegal` or `idx_valid` into an unrelated specifier.
- Idle cycles in the middle of a field must not shift bytes into the wrong lanes.

// File: rtl/opspec_pkg.sv
package opspec_pkg;

    localparam int VAL_W   = 32;
    localparam int VAL_B   = VAL_W / 8;
    localparam int LEN_W   = 4;
    localparam int BIDX_W  = 3;
    localparam int SBIT_W  = $clog2(VAL_W);

    typedef enum logic [3:0] {
        MD_LIT   = 4'h0,
        MD_IMM   = 4'h1,
        MD_INDEX = 4'h4,
        MD_REG   = 4'h5,
        MD_REGD  = 4'h6,
        MD_ADEC  = 4'h7,
        MD_AINC  = 4'h8,
        MD_AINCD = 4'h9,
        MD_BDSP  = 4'hA,
        MD_BDSPD = 4'hB,
        MD_WDSP  = 4'hC,
        MD_WDSPD = 4'hD,
        MD_LDSP  = 4'hE,
        MD_LDSPD = 4'hF
    } mode_t;

    typedef struct packed {
        mode_t             mode;
        logic [3:0]        rnum;
        logic [LEN_W-1:0]  ext;
        logic [SBIT_W-1:0] sbit;
        logic              is_index;
        logic              bare;
    } lead_info_t;

    function automatic logic [SBIT_W-1:0] sbit_of(input logic [LEN_W-1:0] nbytes);
        case (nbytes)
            4'd1:    sbit_of = SBIT_W'(7);
            4'd2:    sbit_of = SBIT_W'(15);
            default: sbit_of = SBIT_W'(VAL_W - 1);
        endcase
    endfunction

    function automatic lead_info_t decode_lead(input logic [7:0] b, input logic [1:0] dsize);
        lead_info_t r;
        r.mode     = MD_LIT;
        r.rnum     = b[3:0];
        r.ext      = '0;
        r.sbit     = SBIT_W'(5);
        r.is_index = 1'b0;
        r.bare     = 1'b0;
        if (b[7:6] == 2'b00) begin
            r.rnum = 4'h0;
            r.bare = 1'b1;
        end else begin
            case (b[7:4])
                4'h4: begin r.mode = MD_INDEX; r.is_index = 1'b1; end
                4'h5: begin r.mode = MD_REG;   r.bare = 1'b1; end
                4'h6: r.mode = MD_REGD;
                4'h7: r.mode = MD_ADEC;
                4'h8: begin
                    if (b[3:0] == 4'hF) begin
                        r.mode = MD_IMM;
                        r.ext  = LEN_W'(1) << dsize;
                        r.sbit = sbit_of(LEN_W'(1) << dsize);
                    end else begin
                        r.mode = MD_AINC;
                    end
                end
                4'h9: r.mode = MD_AINCD;
                4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF: begin
                    r.mode = mode_t'(b[7:4]);
                    r.ext  = LEN_W'(1) << b[6:5] >> 1;
                    r.sbit = sbit_of(LEN_W'(1) << b[6:5] >> 1);
                end
                default: r.mode = MD_LIT;
            endcase
        end
        return r;
    endfunction

    function automatic logic [VAL_W-1:0] sext_at(input logic [VAL_W-1:0] raw,
                                                  input logic [SBIT_W-1:0] sbit);
        logic [VAL_W-1:0] o;
        for (int i = 0; i < VAL_W; i++)
            o[i] = (i > int'(sbit)) ? raw[sbit] : raw[i];
        return o;
    endfunction

endpackage

// File: rtl/opspec_lead_dec.sv
module opspec_lead_dec
    import opspec_pkg::*;
(
    input  logic [7:0]  lead,
    input  logic [1:0]  dsize,
    output lead_info_t  info
);
    always_comb info = decode_lead(lead, dsize);
endmodule

// File: rtl/opspec_field_acc.sv
module opspec_field_acc #(
    parameter int BYTES  = 4,
    parameter int IDX_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wr_byte,
    output logic [8*BYTES-1:0]   raw
);
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                raw[8*g +: 8] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                raw[8*g +: 8] <= wr_byte;
            else if (clr)
                raw[8*g +: 8] <= '0;
        end
    end
endmodule

// File: rtl/opspec_parser.sv
module opspec_parser
    import opspec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    input  logic [1:0]        dsize,
    output logic              done,
    output logic [3:0]        mode,
    output logic [3:0]        reg_num,
    output logic [VAL_W-1:0]  value,
    output logic [LEN_W-1:0]  length,
    output logic              idx_valid,
    output logic [3:0]        idx_reg,
    output logic              illegal
);
    typedef enum logic {ST_LEAD, ST_EXT} state_t;

    state_t             st;
    logic               after_idx;
    logic [LEN_W-1:0]   rem;
    logic [BIDX_W-1:0]  bidx;
    logic [LEN_W-1:0]   len_q;
    mode_t              mode_q;
    logic [3:0]         reg_q, idx_r_q;
    logic [SBIT_W-1:0]  sbit_q;
    logic               idx_v_q, ill_q, done_q;
    lead_info_t         info;
    logic               take, acc_clr, acc_wr;
    logic [BIDX_W-1:0]  acc_idx;
    logic [7:0]         acc_byte;
    logic [VAL_W-1:0]   raw;

    opspec_lead_dec u_dec (.lead(in_byte), .dsize(dsize), .info(info));

    assign in_ready = !done_q;
    assign take     = in_valid && in_ready;

    always_comb begin
        acc_clr  = take && (st == ST_LEAD);
        acc_wr   = take && ((st == ST_EXT) || (info.mode == MD_LIT));
        acc_idx  = (st == ST_LEAD) ? '0 : bidx;
        acc_byte = (st == ST_LEAD) ? {2'b00, in_byte[5:0]} : in_byte;
    end

    opspec_field_acc #(.BYTES(VAL_B), .IDX_W(BIDX_W)) u_acc (
        .clk(clk), .rst(rst), .clr(acc_clr), .wr_en(acc_wr),
        .wr_idx(acc_idx), .wr_byte(acc_byte), .raw(raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_LEAD; after_idx <= 1'b0; rem <= '0; bidx <= '0;
            len_q <= '0; mode_q <= MD_LIT; reg_q <= '0; idx_r_q <= '0;
            sbit_q <= '0; idx_v_q <= 1'b0; ill_q <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (take) begin
                if (st == ST_LEAD) begin
                    len_q <= after_idx ? len_q + 1'b1 : LEN_W'(1);
                    if (!after_idx) begin
                        idx_v_q <= 1'b0;
                        ill_q   <= 1'b0;
                    end
                    if (info.is_index) begin
                        if (after_idx) begin
                            ill_q     <= 1'b1;
                            done_q    <= 1'b1;
                            after_idx <= 1'b0;
                        end else begin
                            idx_v_q   <= 1'b1;
                            idx_r_q   <= info.rnum;
                            after_idx <= 1'b1;
                        end
                    end else begin
                        mode_q <= info.mode;
                        reg_q  <= info.rnum;
                        sbit_q <= info.sbit;
                        bidx   <= '0;
                        rem    <= info.ext;
                        if (after_idx && info.bare)
                            ill_q <= 1'b1;
                        if (info.ext == '0) begin
                            done_q    <= 1'b1;
                            after_idx <= 1'b0;
                        end else begin
                            st <= ST_EXT;
                        end
                    end
                end else begin
                    bidx  <= bidx + 1'b1;
                    rem   <= rem - 1'b1;
                    len_q <= len_q + 1'b1;
                    if (rem == LEN_W'(1)) begin
                        done_q    <= 1'b1;
                        st        <= ST_LEAD;
                        after_idx <= 1'b0;
                    end
                end
            end
        end
    end

    assign done      = done_q;
    assign mode      = mode_q;
    assign reg_num   = reg_q;
    assign value     = sext_at(raw, sbit_q);
    assign length    = len_q;
    assign idx_valid = idx_v_q;
    assign idx_reg   = idx_r_q;
    assign illegal   = ill_q;
endmodule

// File: rtl/opspec_parser_chk.sv
module opspec_parser_chk (
    input logic       clk,
    input logic       rst,
    input logic       done,
    input logic [3:0] mode,
    input logic [3:0] length,
    input logic       idx_valid,
    input logic       illegal
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    literal_len_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !idx_valid && mode == 4'h0) |-> length == 4'd1);

    // R3
    one_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !idx_valid && mode >= 4'h5 && mode <= 4'h9) |-> length == 4'd1);

    // R4
    byte_disp_len_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !idx_valid && (mode == 4'hA || mode == 4'hB)) |-> length == 4'd2);

    // R8
    index_len_chk: assert property (@(posedge clk) disable iff (rst)
        (done && idx_valid) |-> length >= 4'd2);

    // R9
    illegal_needs_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (done && illegal) |-> idx_valid);
endmodule

bind opspec_parser opspec_parser_chk u_chk (
    .clk(clk), .rst(rst), .done(done), .mode(mode), .length(length),
    .idx_valid(idx_valid), .illegal(illegal)
);

// File: tb/sim_opspec_parser.sv
module sim_opspec_parser;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [1:0]  dsize = 2'd0;
    logic        in_ready, done, idx_valid, illegal;
    logic [3:0]  mode, reg_num, length, idx_reg;
    logic [31:0] value;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    opspec_parser u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .dsize(dsize), .done(done), .mode(mode),
        .reg_num(reg_num), .value(value), .length(length),
        .idx_valid(idx_valid), .idx_reg(idx_reg), .illegal(illegal)
    );

    typedef struct packed {
        logic [79:0] bytes;
        logic [3:0]  n;
        logic [1:0]  ds;
        logic [3:0]  md;
        logic [3:0]  rn;
        logic [31:0] val;
        logic [3:0]  len;
        logic        iv;
        logic [3:0]  ir;
        logic        ill;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{80'h3F,         4'd1, 2'd0, 4'h0, 4'h0, 32'hFFFFFFFF, 4'd1, 1'b0, 4'h0, 1'b0}, // R2
        '{80'h15,         4'd1, 2'd0, 4'h0, 4'h0, 32'h00000015, 4'd1, 1'b0, 4'h0, 1'b0}, // R2
        '{80'h01,         4'd1, 2'd3, 4'h0, 4'h0, 32'h00000001, 4'd1, 1'b0, 4'h0, 1'b0}, // R2
        '{80'h53,         4'd1, 2'd0, 4'h5, 4'h3, 32'h0,        4'd1, 1'b0, 4'h0, 1'b0}, // R3
        '{80'h66,         4'd1, 2'd0, 4'h6, 4'h6, 32'h0,        4'd1, 1'b0, 4'h0, 1'b0}, // R3
        '{80'h72,         4'd1, 2'd0, 4'h7, 4'h2, 32'h0,        4'd1, 1'b0, 4'h0, 1'b0}, // R3
        '{80'h83,         4'd1, 2'd0, 4'h8, 4'h3, 32'h0,        4'd1, 1'b0, 4'h0, 1'b0}, // R3
        '{80'h99,         4'd1, 2'd0, 4'h9, 4'h9, 32'h0,        4'd1, 1'b0, 4'h0, 1'b0}, // R3
        '{80'h85,         4'd1, 2'd2, 4'h8, 4'h5, 32'h0,        4'd1, 1'b0, 4'h0, 1'b0}, // R1
        '{80'h80A1,       4'd2, 2'd0, 4'hA, 4'h1, 32'hFFFFFF80, 4'd2, 1'b0, 4'h0, 1'b0}, // R4
        '{80'h1234C2,     4'd3, 2'd0, 4'hC, 4'h2, 32'h00001234, 4'd3, 1'b0, 4'h0, 1'b0}, // R4 R7
        '{80'h7FFFDE,     4'd3, 2'd0, 4'hD, 4'hE, 32'h00007FFF, 4'd3, 1'b0, 4'h0, 1'b0}, // R5
        '{80'h92345678F4, 4'd5, 2'd0, 4'hF, 4'h4, 32'h92345678, 4'd5, 1'b0, 4'h0, 1'b0}, // R5 R7
        '{80'h7FB3,       4'd2, 2'd0, 4'hB, 4'h3, 32'h0000007F, 4'd2, 1'b0, 4'h0, 1'b0}, // R5
        '{80'hFFFF8000E5, 4'd5, 2'd1, 4'hE, 4'h5, 32'hFFFF8000, 4'd5, 1'b0, 4'h0, 1'b0}, // R4
        '{80'h908F,       4'd2, 2'd0, 4'h1, 4'hF, 32'hFFFFFF90, 4'd2, 1'b0, 4'h0, 1'b0}, // R6
        '{80'h80008F,     4'd3, 2'd1, 4'h1, 4'hF, 32'hFFFF8000, 4'd3, 1'b0, 4'h0, 1'b0}, // R6
        '{80'h000000018F, 4'd5, 2'd2, 4'h1, 4'hF, 32'h00000001, 4'd5, 1'b0, 4'h0, 1'b0}, // R6
        '{80'h88776655443322118F, 4'd9, 2'd3, 4'h1, 4'hF, 32'h44332211, 4'd9, 1'b0, 4'h0, 1'b0}, // R6
        '{80'h6345,       4'd2, 2'd0, 4'h6, 4'h3, 32'h0,        4'd2, 1'b1, 4'h5, 1'b0}, // R8
        '{80'h05A247,     4'd3, 2'd0, 4'hA, 4'h2, 32'h00000005, 4'd3, 1'b1, 4'h7, 1'b0}, // R8
        '{80'h12345678E04C, 4'd6, 2'd0, 4'hE, 4'h0, 32'h12345678, 4'd6, 1'b1, 4'hC, 1'b0}, // R8
        '{80'h12348F4A,   4'd4, 2'd1, 4'h1, 4'hF, 32'h00001234, 4'd4, 1'b1, 4'hA, 1'b0}, // R8
        '{80'h4442,       4'd2, 2'd0, 4'h0, 4'h0, 32'h0,        4'd2, 1'b1, 4'h2, 1'b1}, // R9
        '{80'h53,         4'd1, 2'd0, 4'h5, 4'h3, 32'h0,        4'd1, 1'b0, 4'h0, 1'b0}, // R10
        '{80'h1243,       4'd2, 2'd0, 4'h0, 4'h0, 32'h0,        4'd2, 1'b1, 4'h3, 1'b1}, // R9
        '{80'h5548,       4'd2, 2'd0, 4'h0, 4'h0, 32'h0,        4'd2, 1'b1, 4'h8, 1'b1}, // R9
        '{80'h66,         4'd1, 2'd0, 4'h6, 4'h6, 32'h0,        4'd1, 1'b0, 4'h0, 1'b0}  // R10
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [7:0] b, input logic [1:0] ds, input int gap);
        for (int k = 0; k < gap; k++) begin
            @(negedge clk); in_valid = 1'b0; in_byte = 8'hEE;
        end
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; dsize = ds;
        @(posedge clk);
    endtask

    task automatic check_result(input vec_t v, input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R10 done"}, 32'(done), 32'd1);
        chk({tag, " R10 ready low"}, 32'(in_ready), 32'd0);
        chk({tag, " R9 illegal"}, 32'(illegal), 32'(v.ill));
        chk({tag, " R8 length"}, 32'(length), 32'(v.len));
        chk({tag, " R8 idx_valid"}, 32'(idx_valid), 32'(v.iv));
        if (v.iv) chk({tag, " R8 idx_reg"}, 32'(idx_reg), 32'(v.ir));
        if (!v.ill) begin
            chk({tag, " R1 mode"}, 32'(mode), 32'(v.md));
            chk({tag, " R1 reg"}, 32'(reg_num), 32'(v.rn));
            chk({tag, " R7 value"}, value, v.val);
        end
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, 32'(done), 32'd0);
        chk({tag, " R10 ready back"}, 32'(in_ready), 32'd1);
        chk({tag, " R10 fields held"}, 32'(length), 32'(v.len));
    endtask

    task automatic run_vec(input vec_t v, input int gap, input string tag);
        for (int i = 0; i < int'(v.n); i++)
            drive(v.bytes[8*i +: 8], v.ds, (i == 0) ? 0 : gap);
        check_result(v, tag);
    endtask

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12
        chk("R12 done", 32'(done), 32'd0);
        chk("R12 ready", 32'(in_ready), 32'd1);
        chk("R12 idx_valid", 32'(idx_valid), 32'd0);
        chk("R12 illegal", 32'(illegal), 32'd0);

        for (int j = 0; j < NV; j++)
            run_vec(VECS[j], 0, $sformatf("vec%0d", j));

        // R11: idle cycles inside a word displacement and a long immediate
        run_vec(VECS[10], 2, "R11 stall wdisp");
        run_vec(VECS[17], 3, "R11 stall imm");

        // R6: dsize changes after the lead byte must not alter the field length
        drive(8'h8F, 2'd0, 0);
        drive(8'hA5, 2'd3, 0);
        v = '{80'hA58F, 4'd2, 2'd0, 4'h1, 4'hF, 32'hFFFFFFA5, 4'd2, 1'b0, 4'h0, 1'b0};
        check_result(v, "R6 dsize sampled at lead");

        // R2: literal ignores dsize
        run_vec('{80'h20, 4'd1, 2'd3, 4'h0, 4'h0, 32'hFFFFFFE0, 4'd1, 1'b0, 4'h0, 1'b0}, 0, "R2 lit neg");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule